// File: doc/BRIEF.md
# Deserializer Bit-Slip Word Realigner

This block sits behind a serial-to-parallel converter and runs in the low-speed parallel clock domain. A new deserialized word of `WORD_W` bits (8 or 10) arrives on every clock. The block keeps the most recent word and the one before it. From those two words it forms a `WORD_W`-bit output window. A slip counter sets where that window starts, so the word boundary on the output can move one bit at a time relative to the serial stream.

Pattern-detection logic outside the block asks for a slip by raising an alignment request. The request passes through a two-flop synchronizer and an edge detector, so each rising edge moves the boundary by exactly one bit, however long the request stays high. The counter runs modulo `WORD_W`. When it rolls over to zero, the window falls wholly inside the older word. A one-cycle boundary flag marks that transition word, and fully realigned data follows on the next cycle.

Top module: `bitslip_realigner`

## Requirements
- R1: A synchronous active-high reset clears the slip counter, both word registers and the edge detector. After a reset edge, `dout` is all zeros and `boundary_flag` is 0.
- R2: With the slip counter at 0, the word driven on `din` before clock edge E appears unchanged on `dout` after edge E+1.
- R3: With slip counter value k, `dout` equals bits [WORD_W-1+k : k] of {newest word, previous word}. Bit 0 of each word is the earliest-received serial bit, so the output starts k bits later in the stream.
- R4: Each rising edge of `align_req` advances the slip counter by exactly one.
- R5: When the counter is at WORD_W-1, the next slip returns it to 0. On that cycle `dout` equals the previous word exactly.
- R6: `boundary_flag` is high for exactly one cycle: the cycle in which the counter has just rolled over to 0. It is low at all other times.
- R7: If `align_req` is first sampled high at clock edge E, the new counter value applies to `dout` from edge E+2 onward.
- R8: Holding `align_req` high for more cycles, or keeping it low, causes no further slips. The window offset stays where it is.
- R9: `din` is captured on every clock, including cycles in which a slip is applied. No input word is held back.
- R10: `WORD_W` is an elaboration parameter restricted to 8 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-speed parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| align_req | input | 1 | Slip request; each rising edge moves the boundary one bit |
| din | input | WORD_W | Deserialized word, bit 0 received first |
| dout | output | WORD_W | Realigned output word |
| boundary_flag | output | 1 | One-cycle pulse when the slip counter rolls over to 0 |

## Verification
The hardest case to reach is the rollover. It needs WORD_W separate rising edges on the request, each held at least two cycles and separated by a low phase. Only after all of them does the window collapse into the older word and the flag fire. The stimulus builds a long schedule of request pulses with random high and low lengths, plus one long directed hold. This drives the counter around its full range several times, and every output word is compared with a bit-offset model of the random serial stream.

// File: rtl/realign_pkg.sv
package realign_pkg;

    // State of the request synchronizer and edge detector
    typedef struct packed {
        logic meta;   // first synchronizer stage
        logic sync;   // second synchronizer stage
        logic seen;   // delayed copy used for edge detection
    } req_sync_t;

    // Modulo increment used by the slip counter
    function automatic int unsigned step_mod(input int unsigned val, input int unsigned modulus);
        if (val + 1 >= modulus) begin
            return 0;
        end
        return val + 1;
    endfunction

endpackage

// File: rtl/req_edge_det.sv
module req_edge_det
    import realign_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    output logic rise
);

    req_sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = req_in;
        st_d.sync = st_q.meta;
        st_d.seen = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.sync & ~st_q.seen;

endmodule

// File: rtl/word_pair_reg.sv
module word_pair_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_new,
    output logic [W-1:0] word_old
);

    typedef struct packed {
        logic [W-1:0] newer;
        logic [W-1:0] older;
    } pair_t;

    pair_t pr_d, pr_q;

    // A word is taken on every clock, whether or not a slip is applied (R9)
    always_comb begin
        pr_d.newer = din;
        pr_d.older = pr_q.newer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pr_q <= '0;
        end else begin
            pr_q <= pr_d;
        end
    end

    assign word_new = pr_q.newer;
    assign word_old = pr_q.older;

endmodule

// File: rtl/slip_ctr.sv
module slip_ctr
    import realign_pkg::*;
#(
    parameter int W  = 10,
    parameter int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          wrapped
);

    localparam logic [CW-1:0] TOP = CW'(W - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          wrap;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.wrap = 1'b0;
        if (step) begin
            c_d.cnt  = CW'(step_mod(int'(c_q.cnt), W));
            c_d.wrap = (c_q.cnt == TOP);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt     = c_q.cnt;
    assign wrapped = c_q.wrap;

endmodule

// File: rtl/window_mux.sv
module window_mux #(
    parameter int W  = 10,
    parameter int CW = $clog2(W)
) (
    input  logic [W-1:0]  word_new,
    input  logic [W-1:0]  word_old,
    input  logic [CW-1:0] offset,
    output logic [W-1:0]  win
);

    localparam int CAT_W = 2 * W;

    logic [CAT_W-1:0] cat;
    assign cat = {word_new, word_old};

    // One W-way selector per output bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [W-1:0] cand;
        for (genvar j = 0; j < W; j++) begin : g_cand
            assign cand[j] = cat[i + j];
        end
        assign win[i] = cand[offset];
    end

endmodule

// File: rtl/bitslip_realigner.sv
module bitslip_realigner #(
    parameter int WORD_W = 10   // R10: 8 or 10 only
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              align_req,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              boundary_flag
);

    localparam int CNT_W = $clog2(WORD_W);

    if (WORD_W != 8 && WORD_W != 10) begin : g_bad_width
        $error("bitslip_realigner: WORD_W must be 8 or 10");
    end

    logic              slip_go;
    logic [CNT_W-1:0]  slip_cnt;
    logic [WORD_W-1:0] word_new;
    logic [WORD_W-1:0] word_old;

    req_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .req_in (align_req),
        .rise   (slip_go)
    );

    word_pair_reg #(.W(WORD_W)) u_pair (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .word_new (word_new),
        .word_old (word_old)
    );

    slip_ctr #(.W(WORD_W), .CW(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .step    (slip_go),
        .cnt     (slip_cnt),
        .wrapped (boundary_flag)
    );

    window_mux #(.W(WORD_W), .CW(CNT_W)) u_mux (
        .word_new (word_new),
        .word_old (word_old),
        .offset   (slip_cnt),
        .win      (dout)
    );

endmodule

// File: rtl/bitslip_realigner_chk.sv
module bitslip_realigner_chk #(
    parameter int W  = 10,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          slip_go,
    input logic [CW-1:0] slip_cnt,
    input logic          boundary_flag,
    input logic [W-1:0]  dout,
    input logic [W-1:0]  word_old,
    input logic [W-1:0]  word_new
);

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (slip_cnt == '0 && !boundary_flag && dout == '0)); // R1

    AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> word_old == $past(word_new)); // R2

    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (rst)
        slip_go |=> slip_cnt == (($past(slip_cnt) == CW'(W - 1)) ? '0 : CW'($past(slip_cnt) + 1'b1))); // R4

    AST_ONE_PER_EDGE: assert property (@(posedge clk) disable iff (rst) slip_go |=> !slip_go); // R4

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst) slip_cnt <= CW'(W - 1)); // R5

    AST_WRAP_OLDER: assert property (@(posedge clk) disable iff (rst) boundary_flag |-> dout == word_old); // R5

    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst) boundary_flag |-> slip_cnt == '0); // R6

    AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst) boundary_flag |=> !boundary_flag); // R6

    AST_NO_SPURIOUS_SLIP: assert property (@(posedge clk) disable iff (rst) !slip_go |=> $stable(slip_cnt)); // R8

endmodule

bind bitslip_realigner bitslip_realigner_chk #(.W(WORD_W), .CW(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .slip_go       (slip_go),
    .slip_cnt      (slip_cnt),
    .boundary_flag (boundary_flag),
    .dout          (dout),
    .word_old      (word_old),
    .word_new      (word_new)
);

// File: tb/bitslip_realigner_tb.sv
`timescale 1ns/1ps
module bitslip_realigner_tb;

    localparam int W    = 10;   // R10: default width under test
    localparam int NC   = 3000;
    localparam int RSTC = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         align_req;
    logic [W-1:0] din;
    logic [W-1:0] dout;
    logic         boundary_flag;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    logic [W-1:0] w_seq  [0:NC-1];
    bit           rq_seq [0:NC-1];
    int           slips  [0:NC-1];
    bit           fresh  [0:NC-1];

    always #2 clk = ~clk;

    bitslip_realigner #(.WORD_W(W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .align_req     (align_req),
        .din           (din),
        .dout          (dout),
        .boundary_flag (boundary_flag)
    );

    // Output window at bit offset k into {newer, older}, bit 0 earliest (R3)
    function automatic logic [W-1:0] exp_win(input logic [W-1:0] nw, input logic [W-1:0] ow, input int k);
        logic [2*W-1:0] cat;
        logic [W-1:0]   r;
        cat = {nw, ow};
        for (int i = 0; i < W; i++) r[i] = cat[i + k];
        return r;
    endfunction

    function automatic bit is_rise(input int i);
        if (i < 1) return rq_seq[i];
        return rq_seq[i] && !rq_seq[i-1];
    endfunction

    task automatic check_word(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp, input int c);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d dout actual=%h expected=%h", tag, c, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp, input int c);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d boundary_flag actual=%b expected=%b", tag, c, act, exp);
        end
    endtask

    initial begin
        int c;
        int k;
        void'($urandom(32'h1A2B3C4D));
        // Serial stream cut into words; zero during reset
        for (int i = 0; i < NC; i++) begin
            w_seq[i]  = (i < RSTC) ? '0 : W'($urandom);
            rq_seq[i] = 1'b0;
        end
        // Directed: one long hold, must give a single slip (R8)
        for (int i = 10; i < 30; i++) rq_seq[i] = 1'b1;
        // Directed: minimum-length pulses back to back with one-cycle gaps
        for (int i = 40; i < 40 + 3 * 2 * W; i += 3) begin
            rq_seq[i]   = 1'b1;
            rq_seq[i+1] = 1'b1;
        end
        // Random pulses: high 2..6, low 1..8, sometimes a long idle
        c = 40 + 3 * 2 * W + 5;
        while (c < NC - 20) begin
            int hi = 2 + int'($urandom % 5);
            int lo = 1 + int'($urandom % 8);
            if ($urandom % 10 == 0) lo = lo + 15;
            for (int j = 0; j < hi && c < NC; j++) begin
                rq_seq[c] = 1'b1;
                c++;
            end
            c = c + lo;
        end
        // Model: a rise first sampled at edge i takes effect after edge i+2 (R4, R7)
        k = 0;
        for (int i = 0; i < NC; i++) begin
            fresh[i] = (i >= 2) && is_rise(i - 2);
            if (fresh[i]) k++;
            slips[i] = k;
        end
    end

    initial begin
        rst       = 1'b1;
        align_req = 1'b0;
        din       = '0;
        #1;
        for (int c = 0; c < NC; c++) begin
            int    k;
            string tag;
            rst       = (c < RSTC);
            din       = w_seq[c];
            align_req = rq_seq[c];
            @(posedge clk);
            @(negedge clk);
            if (c < RSTC) begin
                check_word("R1", dout, '0, c);
                check_bit("R1", boundary_flag, 1'b0, c);
            end else begin
                k = slips[c] % W;
                if (fresh[c] && k == 0)                      tag = "R5";
                else if (fresh[c])                           tag = "R4,R7";
                else if (c >= 3 && rq_seq[c-2] && rq_seq[c-3]) tag = "R8";
                else if (k == 0)                             tag = "R2";
                else                                         tag = "R3";
                // Every cycle carries a new word through (R9)
                check_word(tag, dout, exp_win(w_seq[c], w_seq[c-1], k), c);
                check_bit("R6", boundary_flag, fresh[c] && k == 0, c);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule